// File: doc/BRIEF.md
# Memory-Mapped Multi-Channel Down Timer

This block is a timer peripheral with a parameterised number of channels (two by default). Each channel has a 32-bit counter that counts down. A word-wide register bus reaches the block through an address, a write strobe, write data and combinational read data. Each channel can run periodically, reloading its interval every time it passes zero, or once, stopping at zero. A per-channel prescaler divides the incoming source tick rate by a power of two. When a channel expires it sets a pending bit in a shared status register. The single interrupt output is raised whenever a pending bit is set and its enable bit is also set. The clock-source field is stored and read back only. `tick_i` is the already-selected source tick, given as a clock enable.

Each channel is driven by a three-state machine. ST_STOP holds the count. ST_LOAD lasts one cycle, copies the interval into the count and makes the reload bit visible. ST_COUNT decrements on each prescaled tick. A control write takes priority over every other transition, with three outcomes:
- A write with the reload bit set goes to ST_LOAD.
- A write with enable set and reload clear goes to ST_COUNT.
- A write with both clear goes to ST_STOP.

Without a control write, the transitions are these:
- ST_LOAD goes to ST_COUNT if enable is set, otherwise to ST_STOP.
- ST_COUNT goes to ST_STOP on a one-shot expiry.
- ST_STOP stays where it is.

Top module: `mm_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Register map, 32-bit registers:
  - Interrupt enable is at 0x00 and interrupt status at 0x04, with bit n belonging to channel n.
  - Channel n has control at 0x10*n+0x10, interval at 0x10*n+0x14 and count at 0x10*n+0x18.
  - Control reads back enable in bit 0, reload in bit 1, source in bits 3:2, prescaler code in bits 6:4 and one-shot in bit 7.
  - The interval reads back as written.
  - The count register ignores writes.
  - Every other offset reads zero.
- R3: A control write with bit 1 set copies the interval into the count on the following clock edge. Bit 1 reads 1 only in the cycle between the write and that edge, and reads 0 afterwards.
- R4: In ST_COUNT the count decreases by exactly one per prescaled tick. It starts from the loaded value, or from the held value when counting is enabled without a reload.
- R5: A prescaler code c gives one prescaled tick every 2^c source ticks. The prescaler phase restarts whenever the channel leaves ST_COUNT, and no tick is counted while `tick_i` is low.
- R6: Periodic mode (bit 7 clear): a prescaled tick that finds the count at zero sets the channel's pending bit and reloads the interval, and counting continues. An interval N therefore gives a period of N+1 prescaled ticks.
- R7: One-shot mode (bit 7 set): a prescaled tick that finds the count at zero sets the pending bit and clears the enable bit. The count then holds at zero.
- R8: A control write that clears enable freezes the count from that clock edge on, well inside a two-tick window. A disabled channel never changes its count.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it. If an expiry and a clear fall in the same cycle, the expiry wins.
- R10: `irq_o` is the OR over channels of the enable bit AND the pending bit.
- R11: Channels are independent: activity on one never changes another channel's count or pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Source tick enable, one pulse per source clock period |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The corner cases the bench targets, and how a wrong design would show itself:
- **Zero boundary.** A period off by one shows up as a count one step early or late. A channel that fires on reaching zero instead of on the tick after it sets pending one tick too soon.
- **Zero interval.** An interval of zero must expire on every tick.
- **One-shot end.** A one-shot channel that failed to drop its enable would reload and keep counting instead of holding zero.
- **Prescaler.** The largest code and the phase restart are checked against exact step counts, so a prescaler that free-ran across a stop would be caught.
- **Stop, gating and bus.** A stop that lags by a tick, a count that moves while `tick_i` is low, a reload bit that sticks, status bits cleared by written zeros, and an unmasked interrupt each change a value read back at the ports.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

    // Control register bit positions (software decodes these)
    localparam int unsigned CTL_EN_BIT     = 0;
    localparam int unsigned CTL_RELOAD_BIT = 1;
    localparam int unsigned CTL_SRC_LSB    = 2;
    localparam int unsigned SRC_W          = 2;
    localparam int unsigned CTL_PRE_LSB    = 4;
    localparam int unsigned PRE_W          = 3;
    localparam int unsigned CTL_ONE_BIT    = 7;

    // Shared register offsets
    localparam int unsigned IRQ_EN_OFF = 32'h00;
    localparam int unsigned IRQ_ST_OFF = 32'h04;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2
    } chan_state_e;

    function automatic int unsigned ctl_off(input int unsigned ch);
        return 32'h10 * ch + 32'h10;
    endfunction

    function automatic int unsigned ivl_off(input int unsigned ch);
        return 32'h10 * ch + 32'h14;
    endfunction

    function automatic int unsigned cnt_off(input int unsigned ch);
        return 32'h10 * ch + 32'h18;
    endfunction

endpackage

// File: rtl/mm_timer_prescale.sv
module mm_timer_prescale
    import mm_timer_pkg::*;
#(
    parameter int CODE_W = PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              step_o
);

    localparam int DIV_W = (1 << CODE_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // mask has code_i low bits set: a step every 2^code ticks
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(code_i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_i) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign step_o = run_i && tick_i && ((phase_q & mask) == mask);

endmodule

// File: rtl/mm_timer_channel.sv
module mm_timer_channel
    import mm_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ctl_we_i,
    input  logic              ivl_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic [CNT_W-1:0]  ivl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              expire_o
);

    chan_state_e state_q, state_d;

    logic             en_q;
    logic             one_q;
    logic [SRC_W-1:0] src_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] ivl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run;
    logic             step;
    logic             at_zero;
    logic             expire;

    // A control write in the same cycle suppresses the step
    assign run     = (state_q == ST_COUNT) && !ctl_we_i;
    assign at_zero = (cnt_q == '0);
    assign expire  = step && at_zero;

    mm_timer_prescale #(
        .CODE_W (PRE_W)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick_i),
        .code_i (pre_q),
        .step_o (step)
    );

    // Next-state logic: control writes take priority
    always_comb begin
        state_d = state_q;
        if (ctl_we_i) begin
            if (wdata_i[CTL_RELOAD_BIT]) begin
                state_d = ST_LOAD;
            end else if (wdata_i[CTL_EN_BIT]) begin
                state_d = ST_COUNT;
            end else begin
                state_d = ST_STOP;
            end
        end else begin
            unique case (state_q)
                ST_STOP:  state_d = ST_STOP;
                ST_LOAD:  state_d = en_q ? ST_COUNT : ST_STOP;
                ST_COUNT: state_d = (expire && one_q) ? ST_STOP : ST_COUNT;
                default:  state_d = ST_STOP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            one_q <= 1'b0;
            src_q <= '0;
            pre_q <= '0;
        end else if (ctl_we_i) begin
            en_q  <= wdata_i[CTL_EN_BIT];
            one_q <= wdata_i[CTL_ONE_BIT];
            src_q <= wdata_i[CTL_SRC_LSB +: SRC_W];
            pre_q <= wdata_i[CTL_PRE_LSB +: PRE_W];
        end else if (expire && one_q) begin
            en_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else if (ivl_we_i) begin
            ivl_q <= wdata_i[CNT_W-1:0];
        end
    end

    // Counter datapath, steered by the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_LOAD) begin
            cnt_q <= ivl_q;
        end else if (step) begin
            if (at_zero) begin
                cnt_q <= one_q ? '0 : ivl_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ctl_o                          = '0;
        ctl_o[CTL_EN_BIT]              = en_q;
        ctl_o[CTL_RELOAD_BIT]          = (state_q == ST_LOAD);
        ctl_o[CTL_SRC_LSB +: SRC_W]    = src_q;
        ctl_o[CTL_PRE_LSB +: PRE_W]    = pre_q;
        ctl_o[CTL_ONE_BIT]             = one_q;
        ivl_o                          = ivl_q;
        cnt_o                          = cnt_q;
        expire_o                       = expire;
    end

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (cnt_q == $past(ivl_q)))
        else $error("interval not copied on reload"); // R3

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !ctl_we_i) |=> (state_q != ST_LOAD))
        else $error("reload strobe lingered"); // R3

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && step && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("count did not drop by one"); // R4

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && one_q) |=> (!en_q && cnt_q == '0 && state_q == ST_STOP))
        else $error("one-shot did not halt at zero"); // R7

    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !ctl_we_i) |=> $stable(cnt_q))
        else $error("stopped count moved"); // R8

    AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> en_q)
        else $error("counting without enable"); // R8

endmodule

// File: rtl/mm_timer_irq.sv
module mm_timer_irq #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we_i,
    input  logic              st_we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    input  logic [NUM_CH-1:0] set_i,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] st_o,
    output logic              irq_o
);

    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] st_q;
    logic [NUM_CH-1:0] clr;

    assign clr = st_we_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we_i) begin
            en_q <= wdata_i;
        end
    end

    // Set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= (st_q & ~clr) | set_i;
        end
    end

    assign en_o  = en_q;
    assign st_o  = st_q;
    assign irq_o = |(en_q & st_q);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_we_i |=> ((st_q & $past(wdata_i & ~set_i)) == '0))
        else $error("status bit survived a one-write"); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((st_q & $past(set_i)) == $past(set_i)))
        else $error("expiry lost"); // R9

endmodule

// File: rtl/mm_down_timer.sv
module mm_down_timer
    import mm_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [NUM_CH-1:0] ctl_we;
    logic [NUM_CH-1:0] ivl_we;
    logic [NUM_CH-1:0] expire;
    logic [NUM_CH-1:0] irq_en;
    logic [NUM_CH-1:0] irq_st;
    logic [DATA_W-1:0] ctl_rd [NUM_CH];
    logic [CNT_W-1:0]  ivl_rd [NUM_CH];
    logic [CNT_W-1:0]  cnt_rd [NUM_CH];
    logic              en_we;
    logic              st_we;

    assign en_we = wr_en_i && (addr_i == ADDR_W'(IRQ_EN_OFF));
    assign st_we = wr_en_i && (addr_i == ADDR_W'(IRQ_ST_OFF));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign ctl_we[g] = wr_en_i && (addr_i == ADDR_W'(ctl_off(g)));
        assign ivl_we[g] = wr_en_i && (addr_i == ADDR_W'(ivl_off(g)));

        mm_timer_channel #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .ctl_we_i (ctl_we[g]),
            .ivl_we_i (ivl_we[g]),
            .wdata_i  (wdata_i),
            .ctl_o    (ctl_rd[g]),
            .ivl_o    (ivl_rd[g]),
            .cnt_o    (cnt_rd[g]),
            .expire_o (expire[g])
        );
    end

    mm_timer_irq #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we_i (en_we),
        .st_we_i (st_we),
        .wdata_i (wdata_i[NUM_CH-1:0]),
        .set_i   (expire),
        .en_o    (irq_en),
        .st_o    (irq_st),
        .irq_o   (irq_o)
    );

    // Read multiplexer, unmapped offsets return zero
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(IRQ_EN_OFF)) begin
            rdata_o[NUM_CH-1:0] = irq_en;
        end
        if (addr_i == ADDR_W'(IRQ_ST_OFF)) begin
            rdata_o[NUM_CH-1:0] = irq_st;
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (addr_i == ADDR_W'(ctl_off(k))) begin
                rdata_o = ctl_rd[k];
            end
            if (addr_i == ADDR_W'(ivl_off(k))) begin
                rdata_o = DATA_W'(ivl_rd[k]);
            end
            if (addr_i == ADDR_W'(cnt_off(k))) begin
                rdata_o = DATA_W'(cnt_rd[k]);
            end
        end
    end

endmodule

// File: tb/mm_down_timer_bench.sv
module mm_down_timer_bench;

    localparam int CLK_PERIOD = 40;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [31:0] ivl;
        logic [2:0]  code;
        logic        one;
        logic [7:0]  wait_n;
        logic [31:0] cnt;
        logic        pend;
        logic        en;
    } vec_t;

    // Channel 0 scenarios: steps = floor((wait_n-1)/2^code) after control write
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'd10, 3'd0, 1'b0, 8'd1,   32'd10, 1'b0, 1'b1},
        '{32'd10, 3'd0, 1'b0, 8'd5,   32'd6,  1'b0, 1'b1},
        '{32'd10, 3'd0, 1'b0, 8'd12,  32'd10, 1'b1, 1'b1},
        '{32'd10, 3'd0, 1'b0, 8'd14,  32'd8,  1'b1, 1'b1},
        '{32'd4,  3'd0, 1'b1, 8'd6,   32'd0,  1'b1, 1'b0},
        '{32'd4,  3'd0, 1'b1, 8'd5,   32'd0,  1'b0, 1'b1},
        '{32'd8,  3'd2, 1'b0, 8'd9,   32'd6,  1'b0, 1'b1},
        '{32'd8,  3'd2, 1'b0, 8'd12,  32'd6,  1'b0, 1'b1},
        '{32'd8,  3'd2, 1'b0, 8'd13,  32'd5,  1'b0, 1'b1},
        '{32'd3,  3'd1, 1'b1, 8'd10,  32'd0,  1'b1, 1'b0},
        '{32'd3,  3'd1, 1'b1, 8'd8,   32'd0,  1'b0, 1'b1},
        '{32'd0,  3'd0, 1'b0, 8'd3,   32'd0,  1'b1, 1'b1},
        '{32'd5,  3'd7, 1'b0, 8'd130, 32'd4,  1'b0, 1'b1},
        '{32'd5,  3'd7, 1'b0, 8'd128, 32'd5,  1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_i;
    logic [7:0]  addr_i;
    logic        wr_en_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    mm_down_timer u_mm_down_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Called at the falling-edge phase; returns one falling edge later
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        addr_i  = a;
        wdata_i = d;
        wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input string what,
                          input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, what, d, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        rst_n   = 1'b0;
        tick_i  = 1'b1;
        addr_i  = '0;
        wr_en_i = 1'b0;
        wdata_i = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1: reset state
        rd_chk("R1", "irq enable", 8'h00, 32'h0);
        rd_chk("R1", "irq status", 8'h04, 32'h0);
        rd_chk("R1", "ch0 control", 8'h10, 32'h0);
        rd_chk("R1", "ch0 interval", 8'h14, 32'h0);
        rd_chk("R1", "ch0 count", 8'h18, 32'h0);
        rd_chk("R1", "ch1 control", 8'h20, 32'h0);
        rd_chk("R1", "ch1 count", 8'h28, 32'h0);
        chk("R1", "irq_o", {31'b0, irq_o}, 32'h0);

        // R3: reload strobe visible for one cycle, then copied, enable off
        bus_wr(8'h24, 32'd50);
        bus_wr(8'h20, 32'h06);
        rd_chk("R3", "reload bit while loading", 8'h20, 32'h06);
        rd_chk("R3", "count before copy", 8'h28, 32'h0);
        wait_n(1);
        rd_chk("R3", "reload bit cleared", 8'h20, 32'h04);
        rd_chk("R3", "count after copy", 8'h28, 32'd50);
        wait_n(3);
        rd_chk("R8", "disabled count held", 8'h28, 32'd50);

        // R2: count register ignores writes
        bus_wr(8'h28, 32'h1234);
        rd_chk("R2", "count write ignored", 8'h28, 32'd50);
        rd_chk("R2", "interval readback", 8'h24, 32'd50);

        // R4: enable without reload counts from held value
        bus_wr(8'h20, 32'h01);
        wait_n(10);
        rd_chk("R4", "ch1 after 10 ticks", 8'h28, 32'd40);
        rd_chk("R11", "ch0 untouched", 8'h18, 32'h0);

        // R5: no counting while tick_i low
        tick_i = 1'b0;
        wait_n(5);
        rd_chk("R5", "gated tick", 8'h28, 32'd40);
        tick_i = 1'b1;

        // R8: disable freezes count at once
        bus_wr(8'h20, 32'h00);
        rd_chk("R8", "frozen at stop", 8'h28, 32'd40);
        wait_n(4);
        rd_chk("R8", "still frozen", 8'h28, 32'd40);
        rd_chk("R8", "control after stop", 8'h20, 32'h00);

        // R7, R9, R10: one-shot on ch1, masked then unmasked interrupt
        bus_wr(8'h24, 32'd2);
        bus_wr(8'h20, 32'h83);
        wait_n(6);
        rd_chk("R7", "one-shot count", 8'h28, 32'd0);
        rd_chk("R7", "one-shot enable cleared", 8'h20, 32'h80);
        rd_chk("R7", "one-shot pending", 8'h04, 32'h2);
        chk("R10", "masked irq", {31'b0, irq_o}, 32'h0);
        bus_wr(8'h04, 32'h1);
        rd_chk("R9", "zero-write leaves bit", 8'h04, 32'h2);
        bus_wr(8'h00, 32'h2);
        chk("R10", "unmasked irq", {31'b0, irq_o}, 32'h1);
        bus_wr(8'h04, 32'h2);
        rd_chk("R9", "one-write clears bit", 8'h04, 32'h0);
        chk("R10", "irq after clear", {31'b0, irq_o}, 32'h0);

        // R2: unmapped offsets
        rd_chk("R2", "unmapped 0x08", 8'h08, 32'h0);
        rd_chk("R2", "unmapped 0x0C", 8'h0C, 32'h0);
        rd_chk("R2", "unmapped 0x1C", 8'h1C, 32'h0);
        rd_chk("R2", "unmapped 0x30", 8'h30, 32'h0);
        rd_chk("R2", "unmapped 0xFC", 8'hFC, 32'h0);

        // Vector table on channel 0
        bus_wr(8'h00, 32'h1);
        for (int v = 0; v < NV; v++) begin
            logic [31:0] ctl;
            logic [31:0] exp_ctl;
            logic [31:0] d;
            ctl     = {24'b0, VECS[v].one, VECS[v].code, 2'b01, 2'b11};
            exp_ctl = {24'b0, VECS[v].one, VECS[v].code, 2'b01, 1'b0, VECS[v].en};
            bus_wr(8'h10, 32'h0);
            bus_wr(8'h04, 32'hFF);
            bus_wr(8'h14, VECS[v].ivl);
            bus_wr(8'h10, ctl);
            wait_n(int'(VECS[v].wait_n));
            bus_rd(8'h18, d);
            if (VECS[v].code != 3'd0) chk("R5", $sformatf("vec %0d count", v), d, VECS[v].cnt);
            else                      chk("R4", $sformatf("vec %0d count", v), d, VECS[v].cnt);
            bus_rd(8'h04, d);
            if (VECS[v].one) chk("R7", $sformatf("vec %0d pending", v), d, {31'b0, VECS[v].pend});
            else             chk("R6", $sformatf("vec %0d pending", v), d, {31'b0, VECS[v].pend});
            rd_chk("R2", $sformatf("vec %0d control", v), 8'h10, exp_ctl);
            rd_chk("R2", $sformatf("vec %0d interval", v), 8'h14, VECS[v].ivl);
            chk("R10", $sformatf("vec %0d irq", v), {31'b0, irq_o}, {31'b0, VECS[v].pend});
        end

        done = 1'b1;
        finish_run();
    end

endmodule